// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a direct-mapped cache that sits between a processor and a slower main memory. It holds the tag, valid and data arrays and the controller that runs them. The processor side presents a word address with a read or write strobe. On a read hit, the requested word comes back in the same cycle with no stall. Every other access raises a stall until the access is finished.

Every write goes through to memory. A write miss first fetches the whole block from memory, installs it and merges the new word into it. The data-array write happens in the compare cycle, before the hit result is known. If the access turns out to be a miss, the refill replaces the wrongly modified word. Blocks that are replaced are dropped with no writeback, because memory already holds every update.

The processor holds a request until it sees a cycle with stall low, and that cycle completes the request. Memory answers a block read with a one-cycle valid pulse that carries the whole block. It answers a word write with a one-cycle acknowledge. Both may arrive after any number of cycles.

Top module: `wtc_cache`

## Requirements
- R1: The word address splits into three fields. The offset is bits [1:0], the index is bits [5:2] and the tag is bits [15:6] (default geometry of 16 entries and 4 words per block). The index selects one entry and the offset selects the word within it.
- R2: A hit requires the entry's valid bit to be set and its stored tag to equal the address tag. A read hit returns the addressed word in the same cycle with `cpu_stall` low and starts no memory traffic.
- R3: Reset clears every valid bit and leaves `mem_rd_req` and `mem_wr_req` low, so the first access to any entry is a miss.
- R4: On a read miss, `cpu_stall` is high from the first cycle. `mem_rd_req` stays high with the block address until `mem_rd_valid` arrives, and the block, its tag and its valid bit are then installed. Exactly one cycle follows with `cpu_stall` low and the requested word on `cpu_rdata`.
- R5: On a write hit, the word goes into the cached block. `mem_wr_req` carries the same address and word until `mem_wr_ack` arrives, and the following cycle has `cpu_stall` low.
- R6: On a write miss, the block is fetched and installed with the written word merged at its offset. The word is then written to memory before the stall is released. A later read of the same block hits.
- R7: The data-array write happens in the compare cycle whether or not the access hits. After a write miss, every other word of the refilled block reads back as its memory value.
- R8: A replaced block is dropped without writeback. A read issues no memory write, and each miss issues exactly one block read.
- R9: While `cpu_stall` is high, and in the completion cycle that follows, changes to `cpu_addr`, `cpu_wdata`, `cpu_rd` and `cpu_wr` have no effect on the access in progress.
- R10: A read strobe and a write strobe asserted together are handled as a write.
- R11: `mem_rd_req` and `mem_rd_addr` stay unchanged until `mem_rd_valid` arrives. `mem_wr_req`, `mem_wr_addr` and `mem_wr_data` stay unchanged until `mem_wr_ack` arrives.
- R12: `mem_rd_req` and `mem_wr_req` are never high together, are never high while `cpu_stall` is low, and stay low when no access is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Word address of the access |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 32 | Word to write |
| cpu_rdata | output | 32 | Word read |
| cpu_stall | output | 1 | Access not yet complete; hold the request |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_addr | output | 14 | Block address (word address without offset) |
| mem_rd_valid | input | 1 | One-cycle pulse: block data present |
| mem_rd_block | input | 128 | Whole block, word 0 in the low bits |
| mem_wr_req | output | 1 | Word write request |
| mem_wr_addr | output | 16 | Word address of the write |
| mem_wr_data | output | 32 | Word to write |
| mem_wr_ack | input | 1 | One-cycle pulse: write accepted |

## Verification
The assertions check the memory handshakes on every cycle. They confirm that request, address and data hold steady until the answer arrives and that the two requests never overlap. They also confirm that the stall covers all memory traffic and drops in the cycle after a write acknowledge or a read-only fill. Only the bench scenarios can show data correctness. That includes hit or miss as seen at the stall, the merged word after a write miss and conflict evictions that re-read memory values. It also covers inputs ignored during a stall, combined strobes handled as a write, and memory always matching the processor's view after each write.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // accept request and compare tags
    ST_FETCH = 2'd1,  // wait for block, install it
    ST_MEMWR = 2'd2,  // wait for memory write acknowledge
    ST_DONE  = 2'd3   // completion cycle, stall low
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (set_en) valid_q[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int ENTRIES = 16,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 4,
  parameter int OFF_W   = 2,
  localparam int BLK_W  = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [BLK_W-1:0]  fill_blk,
  input  logic              fill_merge,
  input  logic [OFF_W-1:0]  fill_off,
  input  logic [WORD_W-1:0] fill_word
);
  logic [WORD_W-1:0] lane_rd [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_q [ENTRIES];
    logic              take_cpu;
    assign take_cpu = fill_merge && (fill_off == OFF_W'(w));

    always_ff @(posedge clk) begin
      if (fill_en) begin
        lane_q[fill_idx] <= take_cpu ? fill_word : fill_blk[w*WORD_W +: WORD_W];
      end else if (wr_en && (wr_off == OFF_W'(w))) begin
        lane_q[wr_idx] <= wr_word;
      end
    end

    assign lane_rd[w] = lane_q[rd_idx];
  end

  assign rd_word = lane_rd[rd_off];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_rd,
  input  logic req_wr,
  input  logic hit,
  input  logic lat_wr,
  input  logic mem_rd_valid,
  input  logic mem_wr_ack,
  output logic stall,
  output logic accept,
  output logic word_wr,
  output logic fill,
  output logic use_lat,
  output logic mem_rd_req,
  output logic mem_wr_req
);
  wtc_state_e state_q, state_d;
  logic       in_idle, rd_miss;

  assign in_idle = (state_q == ST_IDLE);
  assign rd_miss = req_rd && !req_wr && !hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req_wr)       state_d = hit ? ST_MEMWR : ST_FETCH;
        else if (rd_miss) state_d = ST_FETCH;
      end
      ST_FETCH: if (mem_rd_valid) state_d = lat_wr ? ST_MEMWR : ST_DONE;
      ST_MEMWR: if (mem_wr_ack)   state_d = ST_DONE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept     = in_idle && (req_wr || rd_miss);
  assign word_wr    = in_idle && req_wr;
  assign fill       = (state_q == ST_FETCH) && mem_rd_valid;
  assign use_lat    = !in_idle;
  assign mem_rd_req = (state_q == ST_FETCH);
  assign mem_wr_req = (state_q == ST_MEMWR);
  assign stall      = accept || mem_rd_req || mem_wr_req;
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W   = WORDS * WORD_W,
  localparam int BADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               cpu_stall,
  output logic               mem_rd_req,
  output logic [BADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [BLK_W-1:0]   mem_rd_block,
  output logic               mem_wr_req,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [WORD_W-1:0]  mem_wr_data,
  input  logic               mem_wr_ack
);
  logic [ADDR_W-1:0] lat_addr_q;
  logic [WORD_W-1:0] lat_data_q;
  logic              lat_wr_q;
  logic              hit, accept, word_wr, fill, use_lat;

  // field split of the incoming and the captured address
  logic [IDX_W-1:0] c_idx, l_idx, r_idx;
  logic [OFF_W-1:0] c_off, l_off, r_off;
  logic [TAG_W-1:0] c_tag, l_tag;
  assign c_off = cpu_addr[OFF_W-1:0];
  assign c_idx = cpu_addr[OFF_W +: IDX_W];
  assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign l_off = lat_addr_q[OFF_W-1:0];
  assign l_idx = lat_addr_q[OFF_W +: IDX_W];
  assign l_tag = lat_addr_q[ADDR_W-1 -: TAG_W];
  assign r_idx = use_lat ? l_idx : c_idx;
  assign r_off = use_lat ? l_off : c_off;

  // request capture, enabled only when a stalling access is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
      lat_wr_q   <= 1'b0;
    end else if (accept) begin
      lat_addr_q <= cpu_addr;
      lat_data_q <= cpu_wdata;
      lat_wr_q   <= cpu_wr;
    end
  end

  wtc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_rd(cpu_rd), .req_wr(cpu_wr), .hit(hit),
    .lat_wr(lat_wr_q), .mem_rd_valid(mem_rd_valid), .mem_wr_ack(mem_wr_ack),
    .stall(cpu_stall), .accept(accept), .word_wr(word_wr), .fill(fill),
    .use_lat(use_lat), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req)
  );

  wtc_tag_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_idx(c_idx), .lk_tag(c_tag), .lk_hit(hit),
    .set_en(fill), .set_idx(l_idx), .set_tag(l_tag)
  );

  wtc_data_store #(.ENTRIES(ENTRIES), .WORDS(WORDS), .WORD_W(WORD_W),
                   .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk(clk), .rd_idx(r_idx), .rd_off(r_off), .rd_word(cpu_rdata),
    .wr_en(word_wr), .wr_idx(c_idx), .wr_off(c_off), .wr_word(cpu_wdata),
    .fill_en(fill), .fill_idx(l_idx), .fill_blk(mem_rd_block),
    .fill_merge(lat_wr_q), .fill_off(l_off), .fill_word(lat_data_q)
  );

  assign mem_rd_addr = lat_addr_q[ADDR_W-1:OFF_W];
  assign mem_wr_addr = lat_addr_q;
  assign mem_wr_data = lat_data_q;
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  localparam int BADDR_W = ADDR_W - $clog2(WORDS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_stall,
  input logic               mem_rd_req,
  input logic [BADDR_W-1:0] mem_rd_addr,
  input logic               mem_rd_valid,
  input logic               mem_wr_req,
  input logic [ADDR_W-1:0]  mem_wr_addr,
  input logic [WORD_W-1:0]  mem_wr_data,
  input logic               mem_wr_ack
);
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R12
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  // R12
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> cpu_stall);

  // R5
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> (!cpu_stall && !mem_wr_req));

  // R4
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid) |=> (!mem_rd_req && (!cpu_stall || mem_wr_req)));

  // R3
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!mem_rd_req && !mem_wr_req));
endmodule

bind wtc_cache wtc_cache_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
  .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .mem_wr_ack(mem_wr_ack)
);

// File: tb/tb_wtc_cache.sv
module tb_wtc_cache;
  logic         clk, rst_n;
  logic [15:0]  cpu_addr;
  logic         cpu_rd, cpu_wr;
  logic [31:0]  cpu_wdata, cpu_rdata;
  logic         cpu_stall;
  logic         mem_rd_req, mem_rd_valid;
  logic [13:0]  mem_rd_addr;
  logic [127:0] mem_rd_block;
  logic         mem_wr_req, mem_wr_ack;
  logic [15:0]  mem_wr_addr;
  logic [31:0]  mem_wr_data;

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int rcnt = 2, wcnt = 1, lat_seed = 0, cycles = 0;
  bit busy = 0, done = 0;
  logic [31:0] mem_m [int];
  logic [31:0] ref_m [int];
  int mdl_tag [16];
  bit mdl_v [16];

  wtc_cache dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] init_val(int a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [31:0] mget(int a);
    if (mem_m.exists(a)) return mem_m[a];
    return init_val(a);
  endfunction
  function automatic logic [31:0] rget(int a);
    if (ref_m.exists(a)) return ref_m[a];
    return init_val(a);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // memory model with varying latency
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_valid = 1'b0; mem_wr_ack = 1'b0; mem_rd_block = '0;
    end else begin
      if (mem_rd_valid) mem_rd_valid = 1'b0;
      else if (mem_rd_req) begin
        if (rcnt == 0) begin
          for (int w = 0; w < 4; w++)
            mem_rd_block[w*32 +: 32] = mget(int'(mem_rd_addr) * 4 + w);
          mem_rd_valid = 1'b1; rd_cnt++; lat_seed++; rcnt = lat_seed % 4;
        end else rcnt--;
      end
      if (mem_wr_ack) mem_wr_ack = 1'b0;
      else if (mem_wr_req) begin
        if (wcnt == 0) begin
          mem_m[int'(mem_wr_addr)] = mem_wr_data;
          mem_wr_ack = 1'b1; wr_cnt++; lat_seed++; wcnt = (lat_seed * 3) % 5;
        end else wcnt--;
      end
    end
  end

  // R12: no memory traffic while no access is pending, checked every clock
  always @(negedge clk) begin
    #2;
    if (rst_n && !busy && !done)
      chk(!mem_rd_req && !mem_wr_req && !cpu_stall, "R12", "idle traffic",
          {29'd0, mem_rd_req, mem_wr_req, cpu_stall}, 32'd0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one processor access; garble changes inputs during the stall (R9)
  task automatic access(bit wr, bit rd, logic [15:0] a, logic [31:0] d, bit garble, string note);
    int idx = int'(a[5:2]);
    int tg  = int'(a[15:6]);
    bit exp_hit = mdl_v[idx] && (mdl_tag[idx] == tg);
    int rd0 = rd_cnt, wr0 = wr_cnt;
    string rq;
    if (wr) rq = exp_hit ? "R5" : "R6";
    else    rq = exp_hit ? "R2" : "R4";
    busy = 1;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    #1;
    chk(cpu_stall == (wr ? 1'b1 : !exp_hit), rq, {note, " first-cycle stall"},
        {31'd0, cpu_stall}, {31'd0, wr ? 1'b1 : !exp_hit});
    while (cpu_stall) begin
      @(negedge clk);
      if (garble) begin
        cpu_addr = a ^ 16'h0155; cpu_wr = !wr; cpu_rd = !rd; cpu_wdata = ~d;
      end
      #1;
    end
    if (!wr) begin
      chk(cpu_rdata == rget(int'(a)), rq, {note, " read data"}, cpu_rdata, rget(int'(a)));
      chk(wr_cnt == wr0, "R8", {note, " no memory write on read"}, wr_cnt, wr0);
    end else begin
      ref_m[int'(a)] = d;
      chk(wr_cnt == wr0 + 1, rq, {note, " one memory write"}, wr_cnt, wr0 + 1);
      chk(mget(int'(a)) == d, rq, {note, " memory equals cpu view"}, mget(int'(a)), d);
    end
    chk(rd_cnt == rd0 + (exp_hit ? 0 : 1), "R8", {note, " block reads"}, rd_cnt,
        rd0 + (exp_hit ? 0 : 1));
    mdl_v[idx] = 1; mdl_tag[idx] = tg;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    busy = 0;
  endtask

  logic [15:0] lfsr;

  initial begin
    rst_n = 0; cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    for (int i = 0; i < 16; i++) begin mdl_v[i] = 0; mdl_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!cpu_stall && !mem_rd_req && !mem_wr_req, "R3", "reset outputs",
        {29'd0, cpu_stall, mem_rd_req, mem_wr_req}, 32'd0);

    // R3: first access after reset misses; R1 offset selects words of one block
    access(0, 1, 16'h0010, 0, 0, "R3 first read");
    access(0, 1, 16'h0013, 0, 0, "R1 same block word 3");
    access(0, 1, 16'h0011, 0, 0, "R1 same block word 1");
    // R5 write hit then read back
    access(1, 0, 16'h0012, 32'hCAFE0012, 0, "R5 write hit");
    access(0, 1, 16'h0012, 0, 0, "R5 readback");
    // R7 write miss on conflicting tag, same index 4
    access(1, 0, 16'h0052, 32'hBEEF0052, 0, "R7 write miss");
    access(0, 1, 16'h0051, 0, 0, "R7 refilled neighbour");
    access(0, 1, 16'h0052, 0, 0, "R6 merged word");
    // R8 evicted block comes back from memory with its written value
    access(0, 1, 16'h0012, 0, 0, "R8 evicted reread");
    // R10 both strobes handled as write
    access(1, 1, 16'h0020, 32'h1234ABCD, 0, "R10 combined strobes");
    access(0, 1, 16'h0020, 0, 0, "R10 readback");
    // R9 inputs changed during stall are ignored
    access(0, 1, 16'h0304, 0, 1, "R9 read miss garbled");
    access(1, 0, 16'h0308, 32'h0BAD0308, 1, "R9 write garbled");
    access(0, 1, 16'h0304 ^ 16'h0155, 0, 0, "R9 garble target untouched");
    access(0, 1, 16'h0308, 0, 0, "R9 written word");

    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[8], !lfsr[8] || lfsr[11], {8'd0, lfsr[7:0]},
             {lfsr, ~lfsr} ^ 32'(n), lfsr[9], "sweep");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule